// File: doc/BRIEF.md
# Remappable Memory Map Decoder

This block sits between a CPU's 16-bit address bus and the on-chip memories. Each address is mapped to exactly one of five targets: the internal register block, the on-chip RAM, the bootstrap ROM, the main ROM, or external memory. The decode is combinational. It depends on the operating mode and on two small configuration registers inside the block.

The mapping register places the 512-byte RAM and the 64-byte register block at the base of any 4 KB page. If the two share a page, the register block wins. The ROM-control register holds a single enable bit for the 16 KB main ROM. After reset this bit takes a value that depends on the mode. Software can change it only in the two special modes.

In bootstrap mode, a small boot ROM appears just below the main ROM. Vector fetches from the top 64 bytes of the address space are steered into the top of that boot ROM, and the translated address is driven out for the memory to use.

Top module: `mem_map_decoder`

## Requirements
- R1: For every address, exactly one of selReg, selRam, selBootRom, selRom and selExt is high. The order of priority from highest to lowest is registers, RAM, bootstrap ROM, main ROM, external.
- R2: When the ROM enable is 1, addresses 0xC000–0xFFFF that no higher-priority target claims select the main ROM. When the enable is 0, selRom never asserts and that range falls to external memory.
- R3: The ROM enable is loaded while rstN is low. It is 0 if mode is 2'b01 (expanded). It is 1 for 2'b00 (single-chip), 2'b10 (bootstrap) and 2'b11 (test).
- R4: A pulse on romCfgWrEn loads wrData[0] into the ROM enable only in bootstrap or test mode (mode[1]=1). In the other modes the write has no effect.
- R5: Only in bootstrap mode, addresses 0xBF00–0xBFFF select the bootstrap ROM.
- R6: In bootstrap mode, an address in 0xFFC0–0xFFFF selects the bootstrap ROM, and mappedAddr carries the same offset in 0xBFC0–0xBFFF. For every other address, mappedAddr equals addr.
- R7: The RAM is 512 bytes at the base of the page given by mapping bits wrData[7:4]. After reset it is at 0x0000–0x01FF.
- R8: The register block is 64 bytes at the base of the page given by mapping bits wrData[3:0]. After reset it is at 0x1000–0x103F. Inside its range it takes priority over RAM.
- R9: A pulse on mapWrEn loads the mapping register in two cases: in a special mode, or while fewer than 64 busCycle pulses have been seen since reset. Otherwise the write is ignored.
- R10: Any address that no other target claims selects external memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Operating mode: 00 single-chip, 01 expanded, 10 bootstrap, 11 test |
| addr | input | 16 | CPU address |
| busCycle | input | 1 | One pulse per completed bus cycle |
| mapWrEn | input | 1 | Write strobe for the mapping register |
| romCfgWrEn | input | 1 | Write strobe for the ROM-control register |
| wrData | input | 8 | Write data for both configuration registers |
| selReg | output | 1 | Register block select |
| selRam | output | 1 | RAM select |
| selBootRom | output | 1 | Bootstrap ROM select |
| selRom | output | 1 | Main ROM select |
| selExt | output | 1 | External memory select |
| mappedAddr | output | 16 | Address after vector redirection |

## Verification
The hardest case to reach is the edge of the mapping write window. A write must be accepted after exactly 63 bus cycles and refused after 64. The stimulus therefore counts busCycle pulses one by one after reset, issues a write on each side of the limit, and reads the effect back through where RAM now decodes. A second hard case is a locked ROM enable. It is reached by resetting in expanded mode and then attempting a write. Switching into a special mode after reset shows that the mode alone reopens both registers.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXP    = 2'b01,
    MODE_BOOT   = 2'b10,
    MODE_TEST   = 2'b11
  } opMode_e;

  // Write strobes that control hands to the datapath after gating
  typedef struct packed {
    logic mapWe;
    logic romWe;
  } cfgStrobe_t;
endpackage

// File: rtl/mm_ctrl.sv
module mm_ctrl
  import mm_pkg::*;
#(
  parameter int WINDOW = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  opMode_e    mode,
  input  logic       busCycle,
  input  logic       mapWrEn,
  input  logic       romCfgWrEn,
  output cfgStrobe_t strobe
);
  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WINDOW);

  logic [CNT_W-1:0] cycleCnt;
  logic             special;
  logic             windowOpen;

  // Saturating count of bus cycles since reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycleCnt <= '0;
    end else if (busCycle && (cycleCnt != LIMIT)) begin
      cycleCnt <= cycleCnt + 1'b1;
    end
  end

  always_comb begin
    special      = (mode == MODE_BOOT) || (mode == MODE_TEST);
    windowOpen   = (cycleCnt < LIMIT);
    strobe.mapWe = mapWrEn && (special || windowOpen);
    strobe.romWe = romCfgWrEn && special;
  end
endmodule

// File: rtl/mm_datapath.sv
module mm_datapath
  import mm_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          PAGE_W       = 4,
  parameter int          RAM_BYTES    = 512,
  parameter int          REG_BYTES    = 64,
  parameter int          ROM_BYTES    = 16384,
  parameter int          BOOT_BYTES   = 256,
  parameter int          VEC_BYTES    = 64,
  parameter logic [15:0] BOOT_BASE    = 16'hBF00,
  parameter logic [3:0]  RAM_PAGE_RST = 4'h0,
  parameter logic [3:0]  REG_PAGE_RST = 4'h1
) (
  input  logic              clk,
  input  logic              rstN,
  input  opMode_e           mode,
  input  cfgStrobe_t        strobe,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] addr,
  output logic              selReg,
  output logic              selRam,
  output logic              selBootRom,
  output logic              selRom,
  output logic              selExt,
  output logic [ADDR_W-1:0] mappedAddr,
  output logic              romOn,
  output logic [PAGE_W-1:0] ramPage,
  output logic [PAGE_W-1:0] regPage
);
  localparam int OFF_W   = ADDR_W - PAGE_W;
  localparam int RAM_AW  = $clog2(RAM_BYTES);
  localparam int REG_AW  = $clog2(REG_BYTES);
  localparam int ROM_AW  = $clog2(ROM_BYTES);
  localparam int BOOT_AW = $clog2(BOOT_BYTES);
  localparam int VEC_AW  = $clog2(VEC_BYTES);

  logic regHit, ramHit, bootHit, vecHit, romHit;

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ramPage <= RAM_PAGE_RST;
      regPage <= REG_PAGE_RST;
      romOn   <= (mode != MODE_EXP);
    end else begin
      if (strobe.mapWe) begin
        ramPage <= wrData[7:4];
        regPage <= wrData[3:0];
      end
      if (strobe.romWe) begin
        romOn <= wrData[0];
      end
    end
  end

  // Target hits
  always_comb begin
    regHit  = (addr[ADDR_W-1:OFF_W] == regPage) && (addr[OFF_W-1:REG_AW] == '0);
    ramHit  = (addr[ADDR_W-1:OFF_W] == ramPage) && (addr[OFF_W-1:RAM_AW] == '0);
    vecHit  = (mode == MODE_BOOT) && (&addr[ADDR_W-1:VEC_AW]);
    bootHit = ((mode == MODE_BOOT) &&
               (addr[ADDR_W-1:BOOT_AW] == BOOT_BASE[ADDR_W-1:BOOT_AW])) || vecHit;
    romHit  = romOn && (&addr[ADDR_W-1:ROM_AW]);
  end

  // Priority resolution
  always_comb begin
    selReg     = regHit;
    selRam     = !regHit && ramHit;
    selBootRom = !regHit && !ramHit && bootHit;
    selRom     = !regHit && !ramHit && !bootHit && romHit;
    selExt     = !regHit && !ramHit && !bootHit && !romHit;
    if (selBootRom && vecHit) begin
      mappedAddr = {BOOT_BASE[ADDR_W-1:BOOT_AW], addr[BOOT_AW-1:0]};
    end else begin
      mappedAddr = addr;
    end
  end
endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
  import mm_pkg::*;
#(
  parameter int WINDOW = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  mode,
  input  logic [15:0] addr,
  input  logic        busCycle,
  input  logic        mapWrEn,
  input  logic        romCfgWrEn,
  input  logic [7:0]  wrData,
  output logic        selReg,
  output logic        selRam,
  output logic        selBootRom,
  output logic        selRom,
  output logic        selExt,
  output logic [15:0] mappedAddr
);
  cfgStrobe_t strobe;
  opMode_e    modeE;
  logic       romOn;
  logic [3:0] ramPage;
  logic [3:0] regPage;

  assign modeE = opMode_e'(mode);

  mm_ctrl #(.WINDOW(WINDOW)) i_ctrl (
    .clk(clk), .rstN(rstN), .mode(modeE), .busCycle(busCycle),
    .mapWrEn(mapWrEn), .romCfgWrEn(romCfgWrEn), .strobe(strobe)
  );

  mm_datapath i_dp (
    .clk(clk), .rstN(rstN), .mode(modeE), .strobe(strobe), .wrData(wrData),
    .addr(addr), .selReg(selReg), .selRam(selRam), .selBootRom(selBootRom),
    .selRom(selRom), .selExt(selExt), .mappedAddr(mappedAddr),
    .romOn(romOn), .ramPage(ramPage), .regPage(regPage)
  );
endmodule

// File: rtl/mm_checker.sv
module mm_checker #(
  parameter int WINDOW = 64
) (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  mode,
  input logic [15:0] addr,
  input logic        busCycle,
  input logic        mapWrEn,
  input logic        romCfgWrEn,
  input logic [7:0]  wrData,
  input logic        selReg,
  input logic        selRam,
  input logic        selBootRom,
  input logic        selRom,
  input logic        selExt,
  input logic [15:0] mappedAddr,
  input logic        romOn,
  input logic [3:0]  ramPage,
  input logic [3:0]  regPage
);
  localparam int CW = $clog2(WINDOW + 1);
  logic [CW-1:0] seen;

  always_ff @(posedge clk) begin
    if (!rstN) seen <= '0;
    else if (busCycle && (seen != CW'(WINDOW))) seen <= seen + 1'b1;
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $countones({selReg, selRam, selBootRom, selRom, selExt}) == 1); // R1
  AST_ROM_CLAIMS: assert property (@(posedge clk) disable iff (!rstN)
    (romOn && addr[15:14] == 2'b11 && !selReg && !selRam && !selBootRom) |-> selRom); // R2
  AST_ROM_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !romOn |-> !selRom); // R2
  AST_ROM_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    !mode[1] |=> $stable(romOn)); // R4
  AST_BOOT_MODE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    selBootRom |-> (mode == 2'b10)); // R5
  AST_VEC_REDIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (selBootRom && (&addr[15:6])) |-> (mappedAddr == {2'b10, addr[13:0]})); // R6
  AST_REG_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (addr[15:12] == regPage && addr[11:6] == '0) |-> selReg); // R8
  AST_MAP_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (!mode[1] && seen == CW'(WINDOW)) |=> $stable({ramPage, regPage})); // R9
endmodule

bind mem_map_decoder mm_checker #(.WINDOW(WINDOW)) i_chk (.*);

// File: tb/test_mem_map_decoder.sv
module test_mem_map_decoder;
  localparam logic [4:0] S_REG  = 5'b10000;
  localparam logic [4:0] S_RAM  = 5'b01000;
  localparam logic [4:0] S_BOOT = 5'b00100;
  localparam logic [4:0] S_ROM  = 5'b00010;
  localparam logic [4:0] S_EXT  = 5'b00001;

  logic clk = 0, rstN = 0, busCycle = 0, mapWrEn = 0, romCfgWrEn = 0;
  logic [1:0] mode = 2'b00;
  logic [15:0] addr = '0;
  logic [7:0] wrData = '0;
  logic selReg, selRam, selBootRom, selRom, selExt;
  logic [15:0] mappedAddr;
  int nChecks = 0, nErr = 0;

  always #2.5 clk = ~clk;

  mem_map_decoder i_mem_map_decoder (.*);

  task automatic chk(string tag, logic [15:0] a, logic [4:0] exp, logic [15:0] expAddr);
    logic [4:0] got;
    addr = a;
    #1;
    got = {selReg, selRam, selBootRom, selRom, selExt};
    nChecks++;
    if (got !== exp || mappedAddr !== expAddr) begin
      nErr++;
      $display("FAIL %s addr=%h sel=%b mapped=%h expected sel=%b mapped=%h",
               tag, a, got, mappedAddr, exp, expAddr);
    end
  endtask

  task automatic doReset(logic [1:0] m);
    @(negedge clk);
    rstN = 0; mode = m;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  task automatic writeMap(logic [7:0] d);
    @(negedge clk); mapWrEn = 1; wrData = d;
    @(negedge clk); mapWrEn = 0;
  endtask

  task automatic writeRom(logic b);
    @(negedge clk); romCfgWrEn = 1; wrData = {7'd0, b};
    @(negedge clk); romCfgWrEn = 0;
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); busCycle = 1;
      @(negedge clk); busCycle = 0;
    end
  endtask

  task automatic testSingleReset;
    doReset(2'b00);
    chk("R7 ram base", 16'h0000, S_RAM, 16'h0000);
    chk("R7 ram top", 16'h01FF, S_RAM, 16'h01FF);
    chk("R10 past ram", 16'h0200, S_EXT, 16'h0200);
    chk("R8 reg base", 16'h1000, S_REG, 16'h1000);
    chk("R8 reg top", 16'h103F, S_REG, 16'h103F);
    chk("R10 past reg", 16'h1040, S_EXT, 16'h1040);
    chk("R3 rom on single", 16'hC000, S_ROM, 16'hC000);
    chk("R2 rom top", 16'hFFFF, S_ROM, 16'hFFFF);
    chk("R5 no boot in single", 16'hBF00, S_EXT, 16'hBF00);
    chk("R6 no redirect in single", 16'hFFC0, S_ROM, 16'hFFC0);
    writeRom(1'b0);
    chk("R4 rom write ignored single", 16'hC000, S_ROM, 16'hC000);
  endtask

  task automatic testExpanded;
    doReset(2'b01);
    chk("R3 rom off expanded", 16'hC000, S_EXT, 16'hC000);
    chk("R2 rom off top", 16'hFFFF, S_EXT, 16'hFFFF);
    writeRom(1'b1);
    chk("R4 rom write ignored expanded", 16'hE000, S_EXT, 16'hE000);
    writeMap(8'hC1);
    chk("R7 ram moved over rom space", 16'hC100, S_RAM, 16'hC100);
    chk("R7 ram old place", 16'h0000, S_EXT, 16'h0000);
  endtask

  task automatic testBoot;
    doReset(2'b10);
    chk("R5 boot base", 16'hBF00, S_BOOT, 16'hBF00);
    chk("R5 boot top", 16'hBFFF, S_BOOT, 16'hBFFF);
    chk("R10 below boot", 16'hBEFF, S_EXT, 16'hBEFF);
    chk("R3 rom on boot", 16'hC000, S_ROM, 16'hC000);
    chk("R6 vector low", 16'hFFC0, S_BOOT, 16'hBFC0);
    chk("R6 vector high", 16'hFFFE, S_BOOT, 16'hBFFE);
    chk("R6 below vectors", 16'hFFBF, S_ROM, 16'hFFBF);
    writeRom(1'b0);
    chk("R4 rom disabled in boot", 16'hC000, S_EXT, 16'hC000);
    chk("R6 vector with rom off", 16'hFFFF, S_BOOT, 16'hBFFF);
  endtask

  task automatic testTest;
    doReset(2'b11);
    chk("R3 rom on test", 16'hD000, S_ROM, 16'hD000);
    chk("R5 no boot in test", 16'hBF10, S_EXT, 16'hBF10);
    writeRom(1'b0);
    chk("R4 rom disabled in test", 16'hD000, S_EXT, 16'hD000);
    writeRom(1'b1);
    chk("R4 rom re-enabled in test", 16'hD000, S_ROM, 16'hD000);
  endtask

  task automatic testOverlap;
    doReset(2'b00);
    writeMap(8'h11);
    chk("R8 reg over ram", 16'h1000, S_REG, 16'h1000);
    chk("R8 reg over ram top", 16'h103F, S_REG, 16'h103F);
    chk("R1 ram above reg", 16'h1040, S_RAM, 16'h1040);
    chk("R7 ram top moved", 16'h11FF, S_RAM, 16'h11FF);
    chk("R10 past moved ram", 16'h1200, S_EXT, 16'h1200);
    chk("R7 old ram gone", 16'h0000, S_EXT, 16'h0000);
    writeMap(8'h3F);
    chk("R1 reg over rom", 16'hF000, S_REG, 16'hF000);
    chk("R7 ram page 3", 16'h3000, S_RAM, 16'h3000);
  endtask

  task automatic testWindow;
    doReset(2'b00);
    pulses(63);
    writeMap(8'h21);
    chk("R9 write at 63 cycles", 16'h2000, S_RAM, 16'h2000);
    pulses(1);
    writeMap(8'h52);
    chk("R9 write at 64 cycles ignored ram", 16'h2000, S_RAM, 16'h2000);
    chk("R9 write at 64 cycles ignored reg", 16'h1000, S_REG, 16'h1000);
    chk("R9 new ram absent", 16'h5000, S_EXT, 16'h5000);
    @(negedge clk); mode = 2'b11;
    writeMap(8'h52);
    chk("R9 special mode reopens", 16'h5000, S_RAM, 16'h5000);
    chk("R9 reg moved", 16'h2000, S_REG, 16'h2000);
  endtask

  initial begin
    #(200000 * 5);
    nErr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    testSingleReset();
    testExpanded();
    testBoot();
    testTest();
    testOverlap();
    testWindow();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule